// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This block drives a small serial EEPROM over a three-wire link: a chip-select line, a serial clock, a data line into the memory and a data line back from it. Each request reads or writes one 16-bit word at a 6-bit word address. A request is a single cycle on the command port: a start strobe, a read/write select, the address and the write word. The block answers with a one-cycle done pulse, an error flag that is valid with that pulse, and the word read from the memory.

A read is one frame: a 3-bit start-and-opcode field, the address, then 16 clocks during which the memory returns the word. A write takes three frames. The first is a write-enable command. The second carries the opcode, the address and the data word. The third is a ready poll, in which the block pulses the clock and samples the memory's output until it reads 1 or until a retry limit runs out. The serial clock is derived from the system clock by a programmable half-period. The interval between poll pulses and the retry limit are also run-time inputs.

Top module: `ee3w_master`

## Requirements
- R1: After reset, and again once each request has finished, `ee_cs`, `ee_sk` and `ee_di` are low and `busy` is low.
- R2: Each serial bit holds `ee_sk` low for `clk_div` system cycles and then high for `clk_div` cycles. `ee_di` never changes while `ee_sk` stays high, and `ee_sk` is high only while `ee_cs` is high.
- R3: A read (`op_write`=0) is a single frame of 25 clocks. `ee_di` carries 1,1,0, then the address MSB first, then 16 zeros.
- R4: During a read, `ee_do` is sampled at the end of the high phase of each of the last 16 clocks and assembled MSB first. `rdata` holds the word when `done` pulses.
- R5: A write (`op_write`=1) starts with a 9-clock write-enable frame carrying 1,0,0,1,1,0,0,0,0.
- R6: The second write frame has 25 clocks carrying 1,0,1, the address MSB first, then `wdata` MSB first. Between any two frames `ee_cs` stays low for one half-period.
- R7: The third write frame is a poll. Each clock pulse has `ee_di`=0. When `ee_do` reads 0, `ee_sk` stays low for `poll_gap` cycles (0 acts as 1) with `ee_cs` high, and then the next pulse follows. A read of 1 ends the request with `error`=0.
- R8: When the number of poll reads returning 0 reaches `retry_max`, the request ends with `error`=1 (0 acts as 1). With fewer zero reads than the limit, the request still succeeds.
- R9: `done` is high for exactly one cycle. Counted from the edge that accepts `start`, a read ends 50·d edges later and a write ends d·(70+2p)+w·g edges later. Here d is the half-period, p the number of poll pulses, w the number of poll waits and g the poll gap. `error` is high only together with `done`.
- R10: A `start` raised while `busy` is high is ignored. The running request keeps its frames, its timing and its result, and no second `done` follows.
- R11: `clk_div`=0 behaves as a half-period of one system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| op_write | input | 1 | 1 = write word, 0 = read word |
| addr | input | 6 | Word address |
| wdata | input | 16 | Word to write |
| clk_div | input | 8 | Serial clock half-period in system cycles |
| poll_gap | input | 16 | Cycles between ready-poll pulses |
| retry_max | input | 8 | Zero reads allowed before a write fails |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Ready poll ran out of retries; valid with done |
| rdata | output | 16 | Word returned by the last read |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data into the memory |
| ee_do | input | 1 | Serial data out of the memory |

## Verification
The block's results arrive at fixed times. A read completes 50·d edges after acceptance, and a write completes after d·(70+2p)+w·g edges, where p and w follow from how many busy polls the memory model returns against the retry limit. The bench counts edges from the accepting edge and samples one time unit after each edge. It requires `done` to rise exactly on the computed edge and to fall on the next one. Frame contents are captured at each rising `ee_sk` and closed at each falling `ee_cs`, so every frame is compared whole once `done` has been seen. The memory model changes `ee_do` only at rising `ee_sk`, half a bit before the block samples it.

// File: rtl/ee3w_pkg.sv
`timescale 1ns/1ps
package ee3w_pkg;

    // start bit followed by the two opcode bits, sent left to right
    localparam logic [2:0] OPC_READ  = 3'b110;
    localparam logic [2:0] OPC_WRITE = 3'b101;
    localparam logic [2:0] OPC_WREN  = 3'b100;
    localparam int         OPC_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_WAIT
    } ee3w_state_e;

    typedef enum logic [1:0] {
        FR_WREN,
        FR_WRITE,
        FR_READ,
        FR_POLL
    } ee3w_frame_e;

    // per-cycle decision of the sequencer
    typedef struct packed {
        logic clr;
        logic ld;
        logic step;
        logic smp;
        logic miss;
        logic fin;
        logic fin_err;
    } ee3w_act_t;

    function automatic logic in_frame(input ee3w_state_e s);
        return (s == ST_LOW) || (s == ST_HIGH) || (s == ST_WAIT);
    endfunction

endpackage

// File: rtl/ee3w_tick.sv
`timescale 1ns/1ps
module ee3w_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] lim;

    assign lim  = (div == '0) ? '0 : div - DIVW'(1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + DIVW'(1);
    end
endmodule

// File: rtl/ee3w_shifter.sv
`timescale 1ns/1ps
module ee3w_shifter #(
    parameter int FW = 25,
    parameter int DW = 16,
    parameter int CW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [FW-1:0] load_word,
    input  logic [CW-1:0] load_len,
    input  logic          step,
    input  logic          sample,
    input  logic          din,
    output logic          msb,
    output logic [CW-1:0] left,
    output logic [DW-1:0] rx
);
    logic [FW-1:0] tx;

    assign msb = tx[FW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx   <= '0;
            left <= '0;
            rx   <= '0;
        end else if (load) begin
            tx   <= load_word;
            left <= load_len;
        end else if (step) begin
            tx   <= {tx[FW-2:0], 1'b0};
            left <= left - CW'(1);
            if (sample) rx <= {rx[DW-2:0], din};
        end
    end
endmodule

// File: rtl/ee3w_pollctl.sv
`timescale 1ns/1ps
module ee3w_pollctl #(
    parameter int GW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          waiting,
    input  logic [GW-1:0] gap,
    input  logic          miss,
    input  logic [RW-1:0] retry_max,
    output logic          wait_done,
    output logic          exhausted
);
    logic [GW-1:0] wcnt;
    logic [GW-1:0] glim;
    logic [RW-1:0] misses;

    assign glim      = (gap == '0) ? '0 : gap - GW'(1);
    assign wait_done = waiting && (wcnt == glim);
    // a zero read now would be the last one allowed
    assign exhausted = ({1'b0, misses} + (RW+1)'(1)) >= {1'b0, retry_max};

    always_ff @(posedge clk) begin
        if (rst || !waiting) wcnt <= '0;
        else                 wcnt <= wcnt + GW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) misses <= '0;
        else if (miss)  misses <= misses + RW'(1);
    end
endmodule

// File: rtl/ee3w_master.sv
`timescale 1ns/1ps
module ee3w_master
    import ee3w_pkg::*;
#(
    parameter int AW   = 6,
    parameter int DW   = 16,
    parameter int DIVW = 8,
    parameter int GW   = 16,
    parameter int RW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            op_write,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [DIVW-1:0] clk_div,
    input  logic [GW-1:0]   poll_gap,
    input  logic [RW-1:0]   retry_max,
    output logic            busy,
    output logic            done,
    output logic            error,
    output logic [DW-1:0]   rdata,
    output logic            ee_cs,
    output logic            ee_sk,
    output logic            ee_di,
    input  logic            ee_do
);
    localparam int FW = OPC_W + AW + DW;
    localparam int CW = $clog2(FW + 1);

    ee3w_state_e st, st_n;
    ee3w_frame_e fr, fr_n;
    ee3w_act_t   act;

    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic [FW-1:0] ld_word;
    logic [CW-1:0] ld_len;
    logic [CW-1:0] left;
    logic          msb;
    logic          tick;
    logic          wait_done;
    logic          exhausted;

    ee3w_tick #(.DIVW(DIVW)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  ((st == ST_LOW) || (st == ST_HIGH) || (st == ST_GAP)),
        .div  (clk_div),
        .tick (tick)
    );

    ee3w_shifter #(.FW(FW), .DW(DW), .CW(CW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (act.ld),
        .load_word (ld_word),
        .load_len  (ld_len),
        .step      (act.step),
        .sample    (act.smp),
        .din       (ee_do),
        .msb       (msb),
        .left      (left),
        .rx        (rdata)
    );

    ee3w_pollctl #(.GW(GW), .RW(RW)) u_poll (
        .clk       (clk),
        .rst       (rst),
        .clr       (act.clr),
        .waiting   (st == ST_WAIT),
        .gap       (poll_gap),
        .miss      (act.miss),
        .retry_max (retry_max),
        .wait_done (wait_done),
        .exhausted (exhausted)
    );

    always_comb begin
        st_n    = st;
        fr_n    = fr;
        act     = '0;
        ld_word = '0;
        ld_len  = '0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    act.clr = 1'b1;
                    act.ld  = 1'b1;
                    st_n    = ST_LOW;
                    if (op_write) begin
                        fr_n    = FR_WREN;
                        ld_word = {OPC_WREN, 2'b11, {(AW-2){1'b0}}, {DW{1'b0}}};
                        ld_len  = CW'(OPC_W + AW);
                    end else begin
                        fr_n    = FR_READ;
                        ld_word = {OPC_READ, addr, {DW{1'b0}}};
                        ld_len  = CW'(FW);
                    end
                end
            end
            ST_LOW: begin
                if (tick) st_n = ST_HIGH;
            end
            ST_HIGH: begin
                if (tick) begin
                    if (fr == FR_POLL) begin
                        if (ee_do) begin
                            act.fin = 1'b1;
                        end else if (exhausted) begin
                            act.fin     = 1'b1;
                            act.fin_err = 1'b1;
                        end else begin
                            act.miss = 1'b1;
                            st_n     = ST_WAIT;
                        end
                    end else begin
                        act.step = 1'b1;
                        act.smp  = (fr == FR_READ) && (left <= CW'(DW));
                        st_n     = ST_LOW;
                        if (left == CW'(1)) begin
                            unique case (fr)
                                FR_WREN: begin
                                    act.ld  = 1'b1;
                                    ld_word = {OPC_WRITE, req_addr, req_data};
                                    ld_len  = CW'(FW);
                                    fr_n    = FR_WRITE;
                                    st_n    = ST_GAP;
                                end
                                FR_WRITE: begin
                                    fr_n = FR_POLL;
                                    st_n = ST_GAP;
                                end
                                default: act.fin = 1'b1;
                            endcase
                        end
                    end
                    if (act.fin) st_n = ST_IDLE;
                end
            end
            ST_GAP: begin
                if (tick) st_n = ST_LOW;
            end
            ST_WAIT: begin
                if (wait_done) st_n = ST_LOW;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            fr       <= FR_READ;
            done     <= 1'b0;
            error    <= 1'b0;
            req_addr <= '0;
            req_data <= '0;
        end else begin
            st    <= st_n;
            fr    <= fr_n;
            done  <= act.fin;
            error <= act.fin && act.fin_err;
            if (st == ST_IDLE && start) begin
                req_addr <= addr;
                req_data <= wdata;
            end
        end
    end

    assign busy  = (st != ST_IDLE);
    assign ee_cs = in_frame(st);
    assign ee_sk = (st == ST_HIGH);
    assign ee_di = ((st == ST_LOW) || (st == ST_HIGH)) && (fr != FR_POLL) && msb;

endmodule

// File: rtl/ee3w_chk.sv
`timescale 1ns/1ps
module ee3w_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic error,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ee_cs && !ee_sk && !ee_di));

    // R2
    di_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    // R2
    sk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> ee_cs);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9
    error_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    // R10
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

bind ee3w_master ee3w_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .error (error),
    .ee_cs (ee_cs),
    .ee_sk (ee_sk),
    .ee_di (ee_di)
);

// File: tb/tb_ee3w_master.sv
`timescale 1ns/1ps
module tb_ee3w_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_write = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [7:0]  clk_div = 8'd2;
    logic [15:0] poll_gap = 16'd5;
    logic [7:0]  retry_max = 8'd4;
    logic        busy, done, error;
    logic [15:0] rdata;
    logic        ee_cs, ee_sk, ee_di;
    logic        do_r = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ee3w_master dut (
        .clk(clk), .rst(rst), .start(start), .op_write(op_write),
        .addr(addr), .wdata(wdata), .clk_div(clk_div), .poll_gap(poll_gap),
        .retry_max(retry_max), .busy(busy), .done(done), .error(error),
        .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(do_r)
    );

    // memory model and frame recorder
    int          busy_cfg = 0;
    logic [15:0] mem_word = '0;
    logic [31:0] fbits = '0;
    int          fcnt = 0;
    logic        poll_fr = 1'b0;
    logic [31:0] fr_log [64];
    int          fl_log [64];
    int          nf = 0;

    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            if (fcnt > 0) begin
                fr_log[nf % 64] = fbits;
                fl_log[nf % 64] = fcnt;
                nf = nf + 1;
            end
            fcnt  = 0;
            fbits = '0;
            do_r  = 1'b0;
        end else begin
            fcnt  = fcnt + 1;
            fbits = {fbits[30:0], ee_di};
            if (fcnt == 1) poll_fr = !ee_di;
            if (poll_fr)                     do_r = (fcnt > busy_cfg);
            else if (fcnt >= 10 && fcnt <= 25) do_r = mem_word[25 - fcnt];
            else                             do_r = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // op, addr, data, busy polls, half-period
    localparam int NV = 6;
    localparam logic [30:0] VEC [NV] = '{
        {1'b0, 6'h2A, 16'hC3A5, 4'd0, 4'd2},
        {1'b0, 6'h01, 16'h0001, 4'd0, 4'd1},
        {1'b1, 6'h3F, 16'hA55A, 4'd0, 4'd2},
        {1'b1, 6'h10, 16'h8001, 4'd2, 4'd1},
        {1'b1, 6'h05, 16'h1234, 4'd4, 4'd2},
        {1'b0, 6'h00, 16'hFFFF, 4'd0, 4'd3}
    };

    task automatic do_op(input bit op, input logic [5:0] a, input logic [15:0] d,
                         input int bz, input int dv, input int gp, input int rm,
                         input bit poke);
        int lat, de, ge, re, p, w, exp_lat, base;
        bit exp_err;
        clk_div = 8'(dv); poll_gap = 16'(gp); retry_max = 8'(rm);
        busy_cfg = bz; mem_word = d; wdata = d; addr = a; op_write = op;
        base = nf;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        lat = 0;
        forever begin
            @(posedge clk); lat++; #1;
            if (done || lat > 20000) break;
            if (poke && lat == 10) begin start = 1'b1; op_write = ~op; end
            else if (poke && lat == 11) start = 1'b0;
        end
        de = (dv == 0) ? 1 : dv;
        ge = (gp == 0) ? 1 : gp;
        re = (rm == 0) ? 1 : rm;
        if (op) begin
            if (bz < re) begin p = bz + 1; w = bz; exp_err = 1'b0; end
            else         begin p = re;     w = re - 1; exp_err = 1'b1; end
            exp_lat = de * (70 + 2 * p) + w * ge;
        end else begin
            p = 0; w = 0; exp_err = 1'b0;
            exp_lat = 50 * de;
        end
        chk(lat == exp_lat, dv == 0 ? "R11" : "R9", "done latency", lat, exp_lat);
        chk(error == exp_err, exp_err ? "R8" : "R7", "error flag", error, exp_err);
        if (op) begin
            chk(nf - base == 3, "R6", "write frame count", nf - base, 3);
            chk(fl_log[base % 64] == 9 && fr_log[base % 64][8:0] == 9'b100110000,
                "R5", "write-enable frame", fr_log[base % 64][8:0], 9'b100110000);
            chk(fl_log[(base+1) % 64] == 25 &&
                fr_log[(base+1) % 64][24:0] == {3'b101, a, d},
                "R6", "write frame", fr_log[(base+1) % 64][24:0], {3'b101, a, d});
            chk(fl_log[(base+2) % 64] == p && fr_log[(base+2) % 64] == 32'h0,
                "R7", "poll pulses", fl_log[(base+2) % 64], p);
        end else begin
            chk(nf - base == 1, poke ? "R10" : "R3", "read frame count", nf - base, 1);
            chk(fl_log[base % 64] == 25 &&
                fr_log[base % 64][24:0] == {3'b110, a, 16'h0},
                "R3", "read frame", fr_log[base % 64][24:0], {3'b110, a, 16'h0});
            chk(rdata == d, "R4", "read word", rdata, d);
        end
        chk(!busy && !ee_cs && !ee_sk && !ee_di, "R1", "idle pins after done",
            {busy, ee_cs, ee_sk, ee_di}, 0);
        @(posedge clk); #1;
        chk(!done, "R9", "done width", done, 0);
        if (poke) begin
            repeat (60) @(posedge clk);
            #1;
            chk(!busy && nf - base == 1, "R10", "no second request",
                nf - base, 1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !ee_cs && !ee_sk && !ee_di, "R1", "reset state",
            {busy, done, ee_cs, ee_sk, ee_di}, 0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        chk(!busy && !ee_cs, "R1", "idle after reset", {busy, ee_cs}, 0);

        for (int i = 0; i < NV; i++)
            do_op(VEC[i][30], VEC[i][29:24], VEC[i][23:8],
                  int'(VEC[i][7:4]), int'(VEC[i][3:0]), 5, 4, 1'b0);

        // R8 boundary: one below the limit still succeeds
        do_op(1'b1, 6'h2B, 16'h0F0F, 3, 1, 2, 4, 1'b0);
        // R8 limit of zero behaves as one
        do_op(1'b1, 6'h11, 16'h7E81, 1, 1, 3, 0, 1'b0);
        // R11 half-period of zero
        do_op(1'b0, 6'h15, 16'h5AA5, 0, 0, 1, 4, 1'b0);
        // R7 poll gap of zero behaves as one
        do_op(1'b1, 6'h22, 16'hBEEF, 2, 2, 0, 4, 1'b0);
        // R10 start while busy is ignored
        do_op(1'b0, 6'h33, 16'h9669, 0, 1, 5, 4, 1'b1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule